// File: doc/BRIEF.md
# Tearing-synchronized frame start trigger

This block decides the clock cycle in which a new frame transfer to a command-interface display panel may begin. It raises a one-cycle `frame_start` pulse and then waits for the frame to be reported finished before it will accept another trigger. The trigger source is chosen at run time from three options: a free-running internal loop, an external vertical-sync input, or the panel's tearing-effect line. The active level of each of the two external inputs is also programmable.

Both pins pass through a two-stage synchronizer. The synchronized level is converted to "active-high" form using its polarity bit, and only a rising edge of that active level counts as an event. A tearing-effect event does not start the frame at once. It loads a counter with the programmed delay plus a fixed offset of four, and the counter then counts write-strobe periods, one per `wr_tick` pulse, rather than clock cycles. The real wait is therefore the programmed value plus four strobe units, with up to one more unit of phase slack depending on where the event falls relative to the strobe.

The controller is a four-state machine:
- IDLE waits for a trigger.
- TEAR_WAIT counts strobe ticks.
- FIRE is the single cycle in which `frame_start` is high.
- BUSY covers the frame transfer.

Transitions:
- IDLE to FIRE: free mode, or a VSYNC event in sync mode.
- IDLE to TEAR_WAIT: a tearing event in tear mode.
- TEAR_WAIT to FIRE: the last counted tick.
- TEAR_WAIT to IDLE: the mode leaves tear mode.
- FIRE to BUSY: always.
- BUSY to FIRE: `frame_done` in free mode.
- BUSY to IDLE: `frame_done` in any other mode.

Top module: `tear_sync_trigger`

## Requirements
- R1: `sync_mode` encodes the source as 00 internal loop, 01 VSYNC pin, 10 tearing-effect pin, 11 reserved. With 11 selected, `frame_start` never rises, whatever the pins do.
- R2: `frame_start` is high for exactly one clock cycle per trigger.
- R3: In mode 00, from IDLE, `frame_start` is high in the cycle after the mode is first seen. During a transfer it is high in the cycle after `frame_done` is sampled.
- R4: In mode 01, an active edge on `vsync_pin` gives `frame_start` three clock edges after the pin changes: two synchronizer stages plus the state register.
- R5: `vsync_pol` = 0 makes a low level active on `vsync_pin`, and `vsync_pol` = 1 makes a high level active. Only the change into the active level is an event.
- R6: `te_pol` = 1 makes a high level active on `te_pin`, and `te_pol` = 0 makes a low level active. Only the change into the active level is an event.
- R7: After a tearing event in mode 10, `frame_start` is high in the cycle after the (`te_delay` + 4)-th `wr_tick` counted in TEAR_WAIT. With no tick the wait does not advance. This also holds for `te_delay` = 65535, which needs 65539 ticks.
- R8: `te_delay` is captured when the tearing event is accepted. Changing it during the wait has no effect on that wait.
- R9: Pin events that arrive in TEAR_WAIT, FIRE or BUSY are discarded. They neither restart the wait nor cause a later pulse.
- R10: `frame_done` outside BUSY is ignored.
- R11: If `sync_mode` leaves 10 during TEAR_WAIT, the wait is abandoned without a pulse and the block returns to IDLE.
- R12: Reset puts the block in IDLE with `frame_start` low. No pulse follows while the inputs rest at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_pin | input | 1 | Raw VSYNC input, asynchronous |
| te_pin | input | 1 | Raw tearing-effect input, asynchronous |
| vsync_pol | input | 1 | Active level of VSYNC (1 = high) |
| te_pol | input | 1 | Active level of tearing effect (1 = high) |
| sync_mode | input | 2 | Trigger source select |
| te_delay | input | 16 | Tearing delay in strobe units, before the offset of 4 |
| wr_tick | input | 1 | One-cycle pulse per write-strobe period |
| frame_done | input | 1 | One-cycle pulse when a frame transfer ends |
| frame_start | output | 1 | One-cycle pulse that starts a frame transfer |

## Verification
The hardest situation to reach from the ports is a second pin event arriving while a tearing delay is already counting. The discarded event must neither restart nor shorten the count, and the captured delay must survive a rewrite of `te_delay`. The stimulus toggles `te_pin` on every strobe tick during the wait and rewrites `te_delay` part way through, then compares the exact tick count to the pulse with the value fixed at the event. A second hard case is the largest delay. It is reached by holding `wr_tick` high for every cycle, so that the 65539-unit wait fits the run.

// File: rtl/tst_pkg.sv
package tst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_TEAR_WAIT = 2'd1,
        ST_FIRE      = 2'd2,
        ST_BUSY      = 2'd3
    } tst_state_e;

    typedef enum logic [1:0] {
        MODE_FREE  = 2'b00,
        MODE_VSYNC = 2'b01,
        MODE_TEAR  = 2'b10,
        MODE_RSVD  = 2'b11
    } tst_mode_e;

endpackage

// File: rtl/tst_pin_sync.sv
// Synchronizes one asynchronous pin and reports a rising edge of its
// active level, where the active level is chosen by pol (1 = high).
module tst_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic active_rise
);

    localparam int unsigned MSB = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              last_q;
    logic              act_now;
    logic              act_prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    // The previous raw level is kept rather than the previous active
    // level, so a reset value shared by both stages never reads as an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[MSB];
    end

    assign act_now     = pol ? chain_q[MSB] : ~chain_q[MSB];
    assign act_prev    = pol ? last_q       : ~last_q;
    assign active_rise = act_now & ~act_prev;

endmodule

// File: rtl/tst_tick_delay.sv
// Down-counter measured in strobe ticks. A load stores value + OFFSET,
// and expire flags the tick that consumes the last unit. OFFSET must be
// at least 1 so that a zero programmed value still expires.
module tst_tick_delay #(
    parameter int unsigned CW     = 16,
    parameter int unsigned OFFSET = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    input  logic          tick,
    output logic          expire
);

    localparam int unsigned W = CW + 1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= W'(load_val) + W'(OFFSET);
        end else if (run && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expire = run & tick & (cnt_q == W'(1));

endmodule

// File: rtl/tear_sync_trigger.sv
module tear_sync_trigger #(
    parameter int unsigned DELAY_W     = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TEAR_OFFSET = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vsync_pin,
    input  logic               te_pin,
    input  logic               vsync_pol,
    input  logic               te_pol,
    input  logic [1:0]         sync_mode,
    input  logic [DELAY_W-1:0] te_delay,
    input  logic               wr_tick,
    input  logic               frame_done,
    output logic               frame_start
);
    import tst_pkg::*;

    localparam int unsigned N_PINS = 2;
    localparam int unsigned PIN_VS = 0;
    localparam int unsigned PIN_TE = 1;

    tst_state_e state_q;
    tst_state_e state_d;
    tst_mode_e  mode;

    logic [N_PINS-1:0] pin_raw;
    logic [N_PINS-1:0] pin_pol;
    logic [N_PINS-1:0] pin_rise;
    logic              vs_rise;
    logic              te_rise;
    logic              delay_load;
    logic              delay_run;
    logic              delay_expire;

    assign mode            = tst_mode_e'(sync_mode);
    assign pin_raw[PIN_VS] = vsync_pin;
    assign pin_raw[PIN_TE] = te_pin;
    assign pin_pol[PIN_VS] = vsync_pol;
    assign pin_pol[PIN_TE] = te_pol;

    generate
        for (genvar g = 0; g < N_PINS; g++) begin : g_pin
            tst_pin_sync #(
                .STAGES(SYNC_STAGES)
            ) sync_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .pin        (pin_raw[g]),
                .pol        (pin_pol[g]),
                .active_rise(pin_rise[g])
            );
        end
    endgenerate

    assign vs_rise = pin_rise[PIN_VS];
    assign te_rise = pin_rise[PIN_TE];

    tst_tick_delay #(
        .CW    (DELAY_W),
        .OFFSET(TEAR_OFFSET)
    ) delay_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (delay_load),
        .load_val(te_delay),
        .run     (delay_run),
        .tick    (wr_tick),
        .expire  (delay_expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (mode)
                    MODE_FREE:  state_d = ST_FIRE;
                    MODE_VSYNC: if (vs_rise) state_d = ST_FIRE;
                    MODE_TEAR:  if (te_rise) state_d = ST_TEAR_WAIT;
                    MODE_RSVD:  state_d = ST_IDLE;
                endcase
            end
            ST_TEAR_WAIT: begin
                if (mode != MODE_TEAR)  state_d = ST_IDLE;
                else if (delay_expire)  state_d = ST_FIRE;
            end
            ST_FIRE: state_d = ST_BUSY;
            ST_BUSY: begin
                if (frame_done) state_d = (mode == MODE_FREE) ? ST_FIRE : ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        frame_start = (state_q == ST_FIRE);
        delay_load  = (state_q == ST_IDLE) && (mode == MODE_TEAR) && te_rise;
        delay_run   = (state_q == ST_TEAR_WAIT);
    end

endmodule

// File: rtl/tear_sync_trigger_chk.sv
module tear_sync_trigger_chk (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          sync_mode,
    input logic                frame_done,
    input logic                wr_tick,
    input logic                frame_start,
    input tst_pkg::tst_state_e state
);
    import tst_pkg::*;

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    assert_reserved_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode == 2'b11) |=> !frame_start);

    assert_free_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && frame_done && sync_mode == 2'b00) |=> frame_start);

    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !frame_done) |=> !frame_start);

    assert_tick_paced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TEAR_WAIT && !wr_tick && sync_mode == 2'b10) |=> (state == ST_TEAR_WAIT));

    assert_abandon_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TEAR_WAIT && sync_mode != 2'b10) |=> (state == ST_IDLE));

endmodule

bind tear_sync_trigger tear_sync_trigger_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_mode  (sync_mode),
    .frame_done (frame_done),
    .wr_tick    (wr_tick),
    .frame_start(frame_start),
    .state      (state_q)
);

// File: tb/tear_sync_trigger_tb_top.sv
`timescale 1ns/1ps
module tear_sync_trigger_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync_pin = 1'b1;
    logic        te_pin = 1'b0;
    logic        vsync_pol = 1'b0;
    logic        te_pol = 1'b1;
    logic [1:0]  sync_mode = 2'b01;
    logic [15:0] te_delay = 16'd0;
    logic        wr_tick = 1'b0;
    logic        frame_done = 1'b0;
    logic        frame_start;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    tear_sync_trigger dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync_pin  (vsync_pin),
        .te_pin     (te_pin),
        .vsync_pol  (vsync_pol),
        .te_pol     (te_pol),
        .sync_mode  (sync_mode),
        .te_delay   (te_delay),
        .wr_tick    (wr_tick),
        .frame_done (frame_done),
        .frame_start(frame_start)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        pol;
        logic [15:0] dly;
        logic [31:0] exp_n;
    } vec_t;

    // exp_n: clock edges to the pulse (mode 01) or strobe ticks (mode 10)
    localparam vec_t VECS [8] = '{
        '{2'b01, 1'b0, 16'd0,  32'd3},
        '{2'b01, 1'b1, 16'd0,  32'd3},
        '{2'b10, 1'b1, 16'd0,  32'd4},
        '{2'b10, 1'b0, 16'd0,  32'd4},
        '{2'b10, 1'b1, 16'd3,  32'd7},
        '{2'b10, 1'b1, 16'd10, 32'd14},
        '{2'b01, 1'b0, 16'd7,  32'd3},
        '{2'b10, 1'b0, 16'd1,  32'd5}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic prep(input logic [1:0] m, input logic pv, input logic pt, input logic [15:0] d);
        @(negedge clk);
        sync_mode = 2'b11;
        vsync_pol = pv;
        te_pol    = pt;
        vsync_pin = ~pv;
        te_pin    = ~pt;
        te_delay  = d;
        repeat (5) @(negedge clk);
        sync_mode = m;
        @(negedge clk);
    endtask

    task automatic end_frame();
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic watch(input int n, output int cnt);
        cnt = 0;
        repeat (n) begin
            @(negedge clk);
            if (frame_start) cnt++;
        end
    endtask

    task automatic vs_run(output int cyc);
        vsync_pin = vsync_pol;
        cyc = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (frame_start) begin
                cyc = i;
                break;
            end
        end
    endtask

    task automatic te_run(input int limit, input bit toggle, input int change_at,
                          input logic [15:0] new_dly, output int ticks, output bit seen);
        te_pin = te_pol;
        repeat (3) @(negedge clk);
        ticks = 0;
        seen  = 1'b0;
        while (!seen && ticks < limit) begin
            if (ticks == change_at) te_delay = new_dly;
            if (toggle) te_pin = ~te_pin;
            wr_tick = 1'b1;
            @(negedge clk);
            wr_tick = 1'b0;
            ticks++;
            if (frame_start) begin
                seen = 1'b1;
            end else begin
                @(negedge clk);
                if (frame_start) begin
                    seen  = 1'b1;
                    ticks += 1000;
                end
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all R): actual=190000 expected=<190000 cycles");
        summary();
        $finish;
    end

    initial begin
        int  cnt;
        int  ticks;
        bit  seen;

        // R12: reset state
        repeat (3) @(negedge clk);
        check(frame_start == 1'b0, "R12 start low in reset", int'(frame_start), 0);
        rst_n = 1'b1;
        watch(10, cnt);
        check(cnt == 0, "R12 no pulse after reset with idle pins", cnt, 0);

        // Vector table: R4, R5, R6, R7, R2
        foreach (VECS[k]) begin
            prep(VECS[k].mode, VECS[k].pol, VECS[k].pol, VECS[k].dly);
            if (VECS[k].mode == 2'b01) begin
                vs_run(cnt);
                check(cnt == int'(VECS[k].exp_n), "R4 R5 vsync latency", cnt, int'(VECS[k].exp_n));
            end else begin
                te_run(100, 1'b0, -1, 16'd0, ticks, seen);
                check(seen && ticks == int'(VECS[k].exp_n), "R6 R7 tear delay ticks",
                      ticks, int'(VECS[k].exp_n));
            end
            @(negedge clk);
            check(frame_start == 1'b0, "R2 pulse width", int'(frame_start), 0);
            end_frame();
        end

        // R3: internal loop
        prep(2'b11, 1'b0, 1'b1, 16'd0);
        sync_mode = 2'b00;
        @(negedge clk);
        check(frame_start == 1'b1, "R3 free start from idle", int'(frame_start), 1);
        @(negedge clk);
        check(frame_start == 1'b0, "R2 free pulse width", int'(frame_start), 0);
        watch(3, cnt);
        check(cnt == 0, "R3 no pulse while busy", cnt, 0);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        check(frame_start == 1'b1, "R3 restart one cycle after done", int'(frame_start), 1);
        @(negedge clk);
        sync_mode = 2'b11;
        end_frame();

        // R1: reserved mode stays silent
        watch(10, cnt);
        vsync_pin = vsync_pol;
        te_pin    = te_pol;
        watch(6, cnt);
        vsync_pin = ~vsync_pol;
        te_pin    = ~te_pol;
        watch(6, ticks);
        vsync_pin = vsync_pol;
        te_pin    = te_pol;
        watch(8, seen ? ticks : ticks);
        check(cnt == 0 && ticks == 0, "R1 reserved mode no pulse", cnt + ticks, 0);

        // R10: frame_done in idle ignored
        prep(2'b01, 1'b0, 1'b1, 16'd0);
        end_frame();
        watch(5, cnt);
        check(cnt == 0, "R10 stray done no pulse", cnt, 0);
        vs_run(cnt);
        check(cnt == 3, "R10 still idle after stray done", cnt, 3);
        @(negedge clk);
        end_frame();

        // R9: events during busy discarded
        prep(2'b01, 1'b1, 1'b1, 16'd0);
        vs_run(cnt);
        check(cnt == 3, "R9 first vsync trigger", cnt, 3);
        vsync_pin = 1'b0;
        watch(4, cnt);
        vsync_pin = 1'b1;
        watch(8, ticks);
        check(cnt + ticks == 0, "R9 busy edge ignored", cnt + ticks, 0);
        end_frame();
        watch(8, cnt);
        check(cnt == 0, "R9 no late pulse after done", cnt, 0);
        vsync_pin = 1'b0;
        repeat (3) @(negedge clk);
        vs_run(cnt);
        check(cnt == 3, "R9 fresh edge accepted", cnt, 3);
        @(negedge clk);
        end_frame();

        // R9: events during the tear wait discarded
        prep(2'b10, 1'b1, 1'b1, 16'd2);
        te_run(100, 1'b1, -1, 16'd0, ticks, seen);
        check(seen && ticks == 6, "R9 tear edges during wait ignored", ticks, 6);
        @(negedge clk);
        end_frame();

        // R8: delay captured at the event
        prep(2'b10, 1'b1, 1'b1, 16'd5);
        te_run(100, 1'b0, 2, 16'd0, ticks, seen);
        check(seen && ticks == 9, "R8 delay rewrite ignored", ticks, 9);
        @(negedge clk);
        end_frame();

        // R11: leaving tear mode abandons the wait
        prep(2'b10, 1'b1, 1'b1, 16'd3);
        te_pin = 1'b1;
        repeat (3) @(negedge clk);
        repeat (2) begin
            wr_tick = 1'b1;
            @(negedge clk);
            wr_tick = 1'b0;
            @(negedge clk);
        end
        sync_mode = 2'b11;
        repeat (2) @(negedge clk);
        sync_mode = 2'b10;
        cnt = 0;
        repeat (20) begin
            wr_tick = 1'b1;
            @(negedge clk);
            if (frame_start) cnt++;
            wr_tick = 1'b0;
            @(negedge clk);
            if (frame_start) cnt++;
        end
        check(cnt == 0, "R11 abandoned wait gives no pulse", cnt, 0);
        te_pin = 1'b0;
        repeat (3) @(negedge clk);
        te_run(100, 1'b0, -1, 16'd0, ticks, seen);
        check(seen && ticks == 7, "R11 new event after abandon", ticks, 7);
        @(negedge clk);
        end_frame();

        // R7: largest delay, strobe tick every cycle
        prep(2'b10, 1'b1, 1'b1, 16'hFFFF);
        te_pin = 1'b1;
        repeat (3) @(negedge clk);
        wr_tick = 1'b1;
        cnt = 0;
        for (int i = 1; i <= 70000; i++) begin
            @(negedge clk);
            if (frame_start) begin
                cnt = i;
                break;
            end
        end
        wr_tick = 1'b0;
        check(cnt == 65539, "R7 max delay 65535 plus offset", cnt, 65539);
        @(negedge clk);
        check(frame_start == 1'b0, "R2 pulse width after max delay", int'(frame_start), 0);
        end_frame();

        summary();
        $finish;
    end

endmodule